// File: doc/BRIEF.md
# Block Sample-Order Reverser

This block sits between the forward and backward shifting paths of a symmetric FIR cell. It takes samples from the forward path and produces the stream for the backward path. In reversal mode it collects samples in one of two last-in-first-out stores while the other store plays its previous block back in reverse order. A transfer strobe makes the two stores trade roles. The spacing between strobes therefore sets how many samples form one reversed block.

In bypass mode the stores are taken out of the output path. Samples then pass through a shift-register delay line. The tap used on that line is chosen by the decimation factor. Everything in the block moves only on clocks where the active-low shift enable is low. On any other clock the whole block holds its state.

This block has no valid/ready handshake and gives no back-pressure. The upstream filter paces the stream with the shift enable. The downstream path must accept one output on every clock where shift is enabled.

Top module: `sample_reverser`

## Requirements
- R1: After reset, `sample_out` and `overflow` are 0, both stores are empty and store 0 is the one being written.
- R2: On a clock edge with `shift_n` high, nothing is written, read, swapped or shifted. `sample_out` and `overflow` keep their values.
- R3: The stores trade roles only on an edge where `xfer_n` and `shift_n` are both low. On that edge the write store is cleared to empty and the store just filled becomes the read store. A low `xfer_n` while `shift_n` is high has no effect.
- R4: With `reverse_off` = 0, on every shift edge the sample on `sample_in` is pushed into the write store and the newest entry of the read store is popped to `sample_out`. A block of N samples (1 ≤ N ≤ 16) whose last sample is taken on a swap edge appears on `sample_out` newest-first. The first of them appears on the shift edge after that swap edge.
- R5: If the read store is empty on a shift edge, `sample_out` becomes 0 in reversal mode. This holds for every shift edge before the first swap.
- R6: Each store holds 16 samples. A sample pushed into a full write store is dropped and the store's first 16 samples stay intact. `overflow` goes high on that edge and stays high until a swap edge on which no sample is dropped. The read store is not disturbed.
- R7: With `reverse_off` = 1, a sample taken on shift edge e appears on `sample_out` right after the D-th shift edge counted from e (edge e being the first). D is `dec_len`, and the value 0 means 16.
- R8: With `reverse_off` = 1, `overflow` is 0 even if the stores overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 16 | Sample from the forward path |
| xfer_n | input | 1 | Transfer strobe, active low; swaps the stores on a shift edge |
| shift_n | input | 1 | Shift enable, active low |
| reverse_off | input | 1 | 0: reversal through the stores; 1: delay-line bypass |
| dec_len | input | 4 | Bypass delay in shift edges, 1..15, with 0 meaning 16 |
| sample_out | output | 16 | Sample stream for the backward path |
| overflow | output | 1 | A sample was dropped into a full write store since the last clean swap |

## Verification
A wrong store count or a wrong role bit is not visible at once. It shows up one block later, when the read store plays back: samples come out in the wrong order, come out as zeros, or stale samples from an older block come back. The bench therefore checks every output across several blocks, not only the first one. It also changes the block length from one block to the next. A wrong delay tap in bypass shows as an offset of whole samples, visible D edges after the first sample goes in.

// File: rtl/rev_pkg.sv
package rev_pkg;
  // Which store is currently collecting samples.
  typedef enum logic {
    WR_BUF0 = 1'b0,
    WR_BUF1 = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/rev_lifo_buf.sv
module rev_lifo_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         clear,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] cnt_m1;

  assign full   = (count == CW'(DEPTH));
  assign cnt_m1 = count - CW'(1);
  assign top    = (count == '0) ? '0 : mem[cnt_m1[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clear)              count <= '0;
    else if (push && !full)      count <= count + CW'(1);
    else if (pop && count != '0) count <= cnt_m1;
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[count[AW-1:0]] <= din;
  end

  // A store is either the writer or the reader, never both
  p_one_role_r3: assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));
  p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clear) |=> (count == CW'(DEPTH)));
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n) clear |=> (count == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !clear) |=> $stable(count));
endmodule

// File: rtl/rev_delay_line.sv
module rev_delay_line #(
  parameter int W       = 16,
  parameter int MAX_LEN = 16,
  localparam int LW     = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] len_sel,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  taps [MAX_LEN];
  logic [LW-1:0] tap_idx;

  generate
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     taps[i] <= '0;
        else if (shift) taps[i] <= (i == 0) ? din : taps[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  // len_sel of 0 selects the full length
  assign tap_idx = (len_sel == '0) ? LW'(MAX_LEN - 1) : len_sel - LW'(1);
  assign dout    = taps[tap_idx];

  p_tap_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (taps[0] == $past(din)));
  p_tail_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(taps[MAX_LEN-1]));
endmodule

// File: rtl/sample_reverser.sv
module sample_reverser
  import rev_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  sample_in,
  input  logic          xfer_n,
  input  logic          shift_n,
  input  logic          reverse_off,
  input  logic [LW-1:0] dec_len,
  output logic [W-1:0]  sample_out,
  output logic          overflow
);
  logic         shift_en, swap;
  wr_sel_e      wr_sel;
  logic [W-1:0] top_v  [2];
  logic         full_v [2];
  logic [W-1:0] rd_top, rev_q, dly_out;
  logic         wr_full, drop, ovf_q;

  assign shift_en = ~shift_n;
  assign swap     = shift_en & ~xfer_n;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_store
      localparam wr_sel_e MINE = (g == 0) ? WR_BUF0 : WR_BUF1;
      logic is_wr;
      assign is_wr = (wr_sel == MINE);
      rev_lifo_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .push (shift_en & is_wr),
        .pop  (shift_en & ~is_wr),
        .clear(swap & ~is_wr),
        .din  (sample_in),
        .top  (top_v[g]),
        .full (full_v[g])
      );
    end
  endgenerate

  assign rd_top  = (wr_sel == WR_BUF0) ? top_v[1] : top_v[0];
  assign wr_full = (wr_sel == WR_BUF0) ? full_v[0] : full_v[1];
  assign drop    = shift_en & wr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel <= WR_BUF0;
      rev_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (shift_en) begin
      rev_q <= rd_top;
      if (swap) wr_sel <= (wr_sel == WR_BUF0) ? WR_BUF1 : WR_BUF0;
      if (drop)      ovf_q <= 1'b1;
      else if (swap) ovf_q <= 1'b0;
    end
  end

  rev_delay_line #(.W(W), .MAX_LEN(DEPTH)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (shift_en),
    .din    (sample_in),
    .len_sel(dec_len),
    .dout   (dly_out)
  );

  assign sample_out = reverse_off ? dly_out : rev_q;
  assign overflow   = ovf_q & ~reverse_off;

  p_swap_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (wr_sel != $past(wr_sel)));
  p_no_swap_r3: assert property (@(posedge clk) disable iff (!rst_n) !swap |=> $stable(wr_sel));
  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_n |=> ($stable(rev_q) && $stable(ovf_q)));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !wr_full) |=> !ovf_q);
  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n) drop |=> ovf_q);
  p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reverse_off |-> !overflow);
endmodule

// File: tb/sample_reverser_test.sv
`timescale 1ns/1ps
module sample_reverser_test;
  localparam int W = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic xfer_n = 1'b1, shift_n = 1'b1, rev_off = 1'b0;
  logic [3:0] dec_len = 4'd1;
  logic [W-1:0] sample_out;
  logic overflow;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [W-1:0] mbuf [2][DEPTH];
  int mcnt [2];
  int msel;
  logic [W-1:0] mrev;
  logic [W-1:0] mtap [DEPTH];
  logic movf;

  always #2.5 clk = ~clk;

  sample_reverser uut (
    .clk(clk), .rst_n(rst_n), .sample_in(din), .xfer_n(xfer_n), .shift_n(shift_n),
    .reverse_off(rev_off), .dec_len(dec_len), .sample_out(sample_out), .overflow(overflow)
  );

  function automatic void model_reset();
    mcnt[0] = 0; mcnt[1] = 0; msel = 0; mrev = '0; movf = 1'b0;
    for (int i = 0; i < DEPTH; i++) mtap[i] = '0;
  endfunction

  function automatic void model_edge(logic [W-1:0] d, logic xn, logic sn);
    int rd;
    bit drop, swp;
    if (sn) return;
    rd = 1 - msel;
    swp = !xn;
    if (mcnt[rd] > 0) begin
      mrev = mbuf[rd][mcnt[rd]-1];
      mcnt[rd]--;
    end else mrev = '0;
    drop = (mcnt[msel] == DEPTH);
    if (!drop) begin
      mbuf[msel][mcnt[msel]] = d;
      mcnt[msel]++;
    end
    if (swp) begin
      mcnt[rd] = 0;
      msel = rd;
    end
    if (drop) movf = 1'b1;
    else if (swp) movf = 1'b0;
    for (int i = DEPTH - 1; i > 0; i--) mtap[i] = mtap[i-1];
    mtap[0] = d;
  endfunction

  function automatic logic [W-1:0] exp_out();
    int dl;
    dl = (dec_len == 0) ? DEPTH : int'(dec_len);
    return rev_off ? mtap[dl-1] : mrev;
  endfunction

  function automatic logic exp_ovf();
    return movf & ~rev_off;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [W-1:0] d, logic xn, logic sn, string tag);
    @(negedge clk);
    din = d; xfer_n = xn; shift_n = sn;
    @(posedge clk);
    model_edge(d, xn, sn);
    #1;
    check(tag, sample_out, exp_out());
    check({tag, "/ovf"}, {{(W-1){1'b0}}, overflow}, {{(W-1){1'b0}}, exp_ovf()});
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 out", sample_out, '0);
    check("R1 ovf", {{(W-1){1'b0}}, overflow}, '0);

    // R5: nothing read before the first swap; R4 block of 3
    step(16'd10, 1, 0, "R5"); step(16'd11, 1, 0, "R5"); step(16'd12, 0, 0, "R5");
    check("R5 zero", sample_out, '0);
    step(16'd20, 1, 0, "R4"); check("R4 first", sample_out, 16'd12);
    step(16'd21, 1, 0, "R4"); check("R4 mid", sample_out, 16'd11);
    step(16'd22, 0, 0, "R4"); check("R4 last", sample_out, 16'd10);
    // R2 / R3: strobe while shift disabled does nothing
    step(16'd99, 0, 1, "R3"); check("R3 hold", sample_out, 16'd10);
    step(16'd98, 1, 1, "R2"); check("R2 hold", sample_out, 16'd10);
    step(16'd30, 1, 0, "R3"); check("R3 no swap", sample_out, 16'd22);
    step(16'd31, 1, 0, "R4"); check("R4", sample_out, 16'd21);
    step(16'd32, 0, 0, "R4"); check("R4", sample_out, 16'd20);
    // R4 block of one, then R5 exhausted reader gives zero
    step(16'd40, 0, 0, "R4"); check("R4 n1", sample_out, 16'd32);
    step(16'd50, 0, 0, "R4"); check("R4 n1", sample_out, 16'd40);
    step(16'd60, 1, 0, "R4"); check("R4 n1", sample_out, 16'd50);
    step(16'd61, 1, 0, "R5"); check("R5 empty", sample_out, 16'd0);
    step(16'd62, 0, 0, "R5"); check("R5 empty", sample_out, 16'd0);
    step(16'd70, 0, 0, "R4"); check("R4", sample_out, 16'd62);

    // R6: overrun the write store
    for (int i = 0; i < 18; i++) begin
      step(16'(100 + i), 1, 0, "R6");
      if (i == 0) check("R6 reader intact", sample_out, 16'd70);
      if (i == 16) check("R6 flag", {{(W-1){1'b0}}, overflow}, 16'd1);
    end
    step(16'd118, 0, 0, "R6"); check("R6 drop on swap", {{(W-1){1'b0}}, overflow}, 16'd1);
    for (int i = 0; i < 16; i++) begin
      step(16'(200 + i), (i == 15) ? 1'b0 : 1'b1, 0, "R6");
      check("R6 kept", sample_out, 16'(115 - i));
    end
    check("R6 cleared", {{(W-1){1'b0}}, overflow}, 16'd0);

    // R4 / R2: random block lengths with random pauses
    for (int b = 0; b < 40; b++) begin
      int n;
      n = $urandom_range(1, 16);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 3) == 0) step(16'($urandom), 1'($urandom), 1, "R2");
        step(16'($urandom), (k == n - 1) ? 1'b0 : 1'b1, 0, "R4");
      end
    end

    // R7 / R8: bypass with several lengths, stores overrun without strobes
    rev_off = 1'b1;
    foreach (mtap[i]) ; // model taps already track the delay line
    dec_len = 4'd5;
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 4) == 0) step(16'($urandom), 1, 1, "R2");
      step(16'($urandom), 1, 0, "R7");
    end
    check("R8 quiet", {{(W-1){1'b0}}, overflow}, 16'd0);
    dec_len = 4'd0;
    for (int i = 0; i < 40; i++) step(16'($urandom), 1, 0, "R7");
    dec_len = 4'd1;
    for (int i = 0; i < 20; i++) step(16'($urandom), 1, 0, "R8");

    // back to reversal: overrun state visible again
    rev_off = 1'b0;
    for (int b = 0; b < 10; b++) begin
      int n;
      n = $urandom_range(1, 16);
      for (int k = 0; k < n; k++) step(16'($urandom), (k == n - 1) ? 1'b0 : 1'b1, 0, "R4");
    end
    finish_run();
  end
endmodule